// File: doc/BRIEF.md
# Configuration Retry Completion Handler

This block sits in a root complex between the agent that issues configuration requests and the path that returns their completions. It takes one configuration request at a time (address, read or write, write data, byte enables), keeps a copy of it, sends it downstream and waits for the completion. A completion carrying the retry status (code 2) is not passed upward as is. If software visibility is off, the stored request goes out again as a new request. If visibility is on and the request is a read of dword offset 0, the block answers at once with synthetic Vendor ID data instead. A programmable limit bounds the number of reissues. When the limit is used up, the block ends the transaction with an error status.

The controller has four states. `ST_IDLE` accepts a request (IDLE→SEND on `req_valid`). `ST_SEND` drives the stored request on the issue port for one cycle (SEND→WAIT). `ST_WAIT` waits for a completion. From there it goes to SEND when a retry completion must be reissued, or to REPLY on a normal completion, a substitution or an exhausted retry budget. `ST_REPLY` presents the result for one cycle (REPLY→IDLE). A completion decoder classifies each completion as pass, substitute, retry or fail. A saturating counter tracks the reissues.

Top module: `cfg_retry_handler`

## Requirements
- R1: After reset, and after a reset during a transaction, `req_ready` is 1 and `issue_valid` and `rsp_valid` are 0.
- R2: A request accepted on a rising edge with `req_valid` and `req_ready` high appears on the issue port for exactly one cycle, starting the next cycle, with the same address, write flag, write data and byte enables.
- R3: A completion whose status is not 2 is returned on `rsp_status`/`rsp_data` unchanged, with `rsp_valid` high for one cycle, starting the cycle after the completion.
- R4: With `vis_en` low, a completion with status 2 raises `retry_flag` together with `cpl_ack`, and the stored request is issued again the next cycle.
- R5: With `vis_en` high, a status-2 completion of a read whose address bits [11:2] are all zero is answered with status 0 and data 0xFFFF0001, with no reissue and no `retry_flag`. This applies even when the retry limit is reached.
- R6: With `vis_en` high, a status-2 completion of a write, or of a read at any other offset, is still reissued as in R4.
- R7: While a transaction is open, `req_ready` is 0. Any request offered then is ignored, and every reissue carries the original fields.
- R8: When a status-2 completion arrives after `max_retry` reissues have already been made, and R5 does not apply, the block responds with status 4 and all-ones data. It makes no further issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vis_en | input | 1 | Software visibility enable for retry status |
| max_retry | input | CNT_W | Number of reissues allowed per request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Configuration address; low OFF_W bits are the register offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables |
| issue_valid | output | 1 | Request sent downstream this cycle |
| issue_addr | output | ADDR_W | Issued address |
| issue_write | output | 1 | Issued write flag |
| issue_wdata | output | DATA_W | Issued write data |
| issue_be | output | BE_W | Issued byte enables |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status (0 ok, 1 unsupported, 2 retry, 4 abort) |
| cpl_data | input | DATA_W | Completion data |
| cpl_ack | output | 1 | Completion consumed this cycle |
| retry_flag | output | 1 | Consumed completion was a retry that will be reissued |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_status | output | 3 | Result status |
| rsp_data | output | DATA_W | Result data |

## Verification
A table of transactions varies the access kind (read or write), the offset (dword 0 at two byte addresses, and other dwords), the visibility bit, the number of retry completions delivered before the final one, and the retry limit. Plain completions with success or unsupported status separate pass-through from substitution. Reads at offset 0 with visibility on, compared with writes to offset 0 and reads of offset 4, show that substitution depends on the read-offset-0 condition and not on visibility alone. Runs with retry counts above the limit, including a limit of zero, separate a reissue from the error ending, and one such run checks that substitution takes priority over the limit. Requests offered while a transaction is open, and a reset during a wait, check that the stored request is not disturbed.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;

    localparam logic [2:0] CS_OK    = 3'd0;
    localparam logic [2:0] CS_UR    = 3'd1;
    localparam logic [2:0] CS_CRS   = 3'd2;
    localparam logic [2:0] CS_ABORT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_REPLY
    } cfgrt_state_e;

    typedef enum logic [1:0] {
        VD_PASS,
        VD_SUBST,
        VD_RETRY,
        VD_FAIL
    } cfgrt_verdict_e;

endpackage

// File: rtl/cfgrt_req_store.sv
module cfgrt_req_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [BE_W-1:0]   in_be,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_write,
    output logic [DATA_W-1:0] q_wdata,
    output logic [BE_W-1:0]   q_be
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_wdata <= '0;
            q_be    <= '0;
        end else if (load) begin
            q_addr  <= in_addr;
            q_write <= in_write;
            q_wdata <= in_wdata;
            q_be    <= in_be;
        end
    end

endmodule

// File: rtl/cfgrt_retry_ctr.sv
module cfgrt_retry_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic             exhausted
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exhausted = (cnt_q >= limit);

    AST_BUMP_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> !exhausted); // R8

endmodule

// File: rtl/cfgrt_cpl_decode.sv
module cfgrt_cpl_decode #(
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic                  [2:0]        status,
    input  logic                  [DATA_W-1:0] data,
    input  logic                               vis_en,
    input  logic                               is_write,
    input  logic                  [OFF_W-1:2]  dword_off,
    input  logic                               exhausted,
    output cfgrt_pkg::cfgrt_verdict_e          verdict,
    output logic                  [2:0]        out_status,
    output logic                  [DATA_W-1:0] out_data
);
    import cfgrt_pkg::*;

    localparam logic [DATA_W-1:0] SUBST_DATA = {{(DATA_W-16){1'b1}}, 16'h0001};

    logic is_crs;
    logic at_zero;

    assign is_crs  = (status == CS_CRS);
    assign at_zero = (dword_off == '0);

    always_comb begin
        if (!is_crs) begin
            verdict    = VD_PASS;
            out_status = status;
            out_data   = data;
        end else if (vis_en && !is_write && at_zero) begin
            verdict    = VD_SUBST;
            out_status = CS_OK;
            out_data   = SUBST_DATA;
        end else if (exhausted) begin
            verdict    = VD_FAIL;
            out_status = CS_ABORT;
            out_data   = '1;
        end else begin
            verdict    = VD_RETRY;
            out_status = status;
            out_data   = data;
        end
    end

endmodule

// File: rtl/cfg_retry_handler.sv
module cfg_retry_handler #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vis_en,
    input  logic [CNT_W-1:0]  max_retry,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              issue_valid,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_write,
    output logic [DATA_W-1:0] issue_wdata,
    output logic [BE_W-1:0]   issue_be,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              cpl_ack,
    output logic              retry_flag,
    output logic              rsp_valid,
    output logic [2:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data
);
    import cfgrt_pkg::*;

    cfgrt_state_e   state_q, state_d;
    cfgrt_verdict_e verdict;
    logic           accept;
    logic           take_cpl;
    logic           exhausted;
    logic [2:0]        dec_status;
    logic [DATA_W-1:0] dec_data;
    logic [2:0]        res_status_q;
    logic [DATA_W-1:0] res_data_q;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign take_cpl = (state_q == ST_WAIT) && cpl_valid;

    cfgrt_req_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .in_addr  (req_addr),
        .in_write (req_write),
        .in_wdata (req_wdata),
        .in_be    (req_be),
        .q_addr   (issue_addr),
        .q_write  (issue_write),
        .q_wdata  (issue_wdata),
        .q_be     (issue_be)
    );

    cfgrt_retry_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .bump      (take_cpl && verdict == VD_RETRY),
        .limit     (max_retry),
        .exhausted (exhausted)
    );

    cfgrt_cpl_decode #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .status     (cpl_status),
        .data       (cpl_data),
        .vis_en     (vis_en),
        .is_write   (issue_write),
        .dword_off  (issue_addr[OFF_W-1:2]),
        .exhausted  (exhausted),
        .verdict    (verdict),
        .out_status (dec_status),
        .out_data   (dec_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SEND;
            ST_SEND:  state_d = ST_WAIT;
            ST_WAIT:  if (cpl_valid) state_d = (verdict == VD_RETRY) ? ST_SEND : ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_status_q <= CS_OK;
            res_data_q   <= '0;
        end else if (take_cpl && verdict != VD_RETRY) begin
            res_status_q <= dec_status;
            res_data_q   <= dec_data;
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        issue_valid = 1'b0;
        cpl_ack     = 1'b0;
        retry_flag  = 1'b0;
        rsp_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready   = 1'b1;
            ST_SEND:  issue_valid = 1'b1;
            ST_WAIT: begin
                cpl_ack    = cpl_valid;
                retry_flag = cpl_valid && (verdict == VD_RETRY);
            end
            ST_REPLY: rsp_valid   = 1'b1;
            default:  req_ready   = 1'b0;
        endcase
        rsp_status = res_status_q;
        rsp_data   = res_data_q;
    end

    AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid); // R2
    AST_RETRY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        retry_flag |-> cpl_ack); // R4
    AST_RETRY_REISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        retry_flag |=> issue_valid); // R4
    AST_NO_CRS_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_status != CS_CRS); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(issue_addr) && $stable(issue_wdata) && $stable(issue_be)); // R7
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == CS_ABORT && $past(cpl_status) == CS_CRS) |-> rsp_data == '1); // R8
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, issue_valid, rsp_valid})); // R7

endmodule

// File: tb/cfg_retry_handler_test.sv
module cfg_retry_handler_test;

    typedef struct packed {
        logic [11:0] off;
        logic        wr;
        logic        vis;
        logic [3:0]  ncrs;
        logic [2:0]  fst;
        logic [31:0] fdat;
        logic [3:0]  maxr;
        logic        poke;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{12'h010, 1'b0, 1'b0, 4'd0, 3'd0, 32'h12345678, 4'd3, 1'b0},
        '{12'h000, 1'b0, 1'b0, 4'd2, 3'd0, 32'hABCD1234, 4'd3, 1'b1},
        '{12'h000, 1'b0, 1'b1, 4'd3, 3'd0, 32'h0BADF00D, 4'd3, 1'b0},
        '{12'h003, 1'b0, 1'b1, 4'd1, 3'd0, 32'h0BADF00D, 4'd3, 1'b0},
        '{12'h004, 1'b0, 1'b1, 4'd2, 3'd0, 32'h000055AA, 4'd3, 1'b1},
        '{12'h000, 1'b1, 1'b1, 4'd1, 3'd0, 32'h00000000, 4'd3, 1'b0},
        '{12'h020, 1'b0, 1'b0, 4'd5, 3'd0, 32'h11112222, 4'd2, 1'b1},
        '{12'h040, 1'b1, 1'b0, 4'd1, 3'd0, 32'h00000000, 4'd0, 1'b0},
        '{12'h008, 1'b0, 1'b0, 4'd0, 3'd1, 32'hFFFFFFFF, 4'd3, 1'b0},
        '{12'h000, 1'b0, 1'b1, 4'd0, 3'd0, 32'h14E4ABCD, 4'd3, 1'b0},
        '{12'h000, 1'b0, 1'b1, 4'd4, 3'd0, 32'h0BADF00D, 4'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vis_en = 1'b0;
    logic [3:0]  max_retry = 4'd3;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        issue_valid;
    logic [31:0] issue_addr;
    logic        issue_write;
    logic [31:0] issue_wdata;
    logic [3:0]  issue_be;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;
    logic        cpl_ack;
    logic        retry_flag;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfg_retry_handler uut (
        .clk(clk), .rst_n(rst_n), .vis_en(vis_en), .max_retry(max_retry),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
        .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_write(issue_write),
        .issue_wdata(issue_wdata), .issue_be(issue_be),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
        .cpl_ack(cpl_ack), .retry_flag(retry_flag),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] a, wd;
        logic [3:0]  be;
        logic [2:0]  est;
        logic [31:0] edat;
        int eiss, crs_sent, issues, flags;
        string tag;
        a  = {20'h00123, v.off};
        wd = {v.off, v.off, 8'hA5};
        be = v.wr ? 4'h3 : 4'hF;
        crs_sent = 0; issues = 0; flags = 0;
        if (v.ncrs == 0) begin
            est = v.fst; edat = v.fdat; eiss = 1; tag = "R3";
        end else if (v.vis && !v.wr && v.off[11:2] == 0) begin
            est = 3'd0; edat = 32'hFFFF0001; eiss = 1; tag = "R5";
        end else if (v.ncrs > v.maxr) begin
            est = 3'd4; edat = 32'hFFFFFFFF; eiss = int'(v.maxr) + 1; tag = "R8";
        end else begin
            est = v.fst; edat = v.fdat; eiss = int'(v.ncrs) + 1; tag = v.vis ? "R6" : "R4";
        end
        @(negedge clk);
        max_retry = v.maxr; vis_en = v.vis;
        check(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_write = v.wr; req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (!issue_valid) break;
            issues++;
            check(issue_addr == a && issue_wdata == wd && issue_be == be && issue_write == v.wr,
                  (k == 0) ? "R2" : "R7", issue_addr, a);
            @(negedge clk);
            cpl_valid = 1'b1;
            if (crs_sent < int'(v.ncrs)) begin
                cpl_status = 3'd2; cpl_data = 32'hDEAD0000; crs_sent++;
            end else begin
                cpl_status = v.fst; cpl_data = v.fdat;
            end
            if (v.poke && k == 0) begin
                req_valid = 1'b1; req_addr = ~a; req_wdata = ~wd; req_be = ~be;
            end
            #1;
            if (retry_flag) flags++;
            check(cpl_ack == 1'b1, "R4", 32'(cpl_ack), 32'd1);
            if (v.poke && k == 0) check(req_ready == 1'b0, "R7", 32'(req_ready), 32'd0);
            @(negedge clk);
            cpl_valid = 1'b0; req_valid = 1'b0;
        end
        check(rsp_valid == 1'b1, tag, 32'(rsp_valid), 32'd1);
        check(rsp_status == est, tag, 32'(rsp_status), 32'(est));
        check(rsp_data == edat, tag, rsp_data, edat);
        check(issues == eiss, tag, 32'(issues), 32'(eiss));
        check(flags == eiss - 1, tag, 32'(flags), 32'(eiss - 1));
        @(negedge clk);
        check(req_ready == 1'b1 && issue_valid == 1'b0 && rsp_valid == 1'b0, "R7",
              {29'd0, req_ready, issue_valid, rsp_valid}, 32'd4);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && issue_valid == 1'b0 && rsp_valid == 1'b0, "R1",
              {29'd0, req_ready, issue_valid, rsp_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && issue_valid == 1'b0 && rsp_valid == 1'b0, "R1",
              {29'd0, req_ready, issue_valid, rsp_valid}, 32'd4);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset while waiting for a completion
        @(negedge clk);
        vis_en = 1'b0; req_valid = 1'b1; req_addr = 32'h00456010; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(issue_valid == 1'b1, "R2", 32'(issue_valid), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(req_ready == 1'b1 && issue_valid == 1'b0 && rsp_valid == 1'b0, "R1",
              {29'd0, req_ready, issue_valid, rsp_valid}, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1",
              {30'd0, req_ready, rsp_valid}, 32'd2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule